// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for an out-of-order core. Each instruction that issues is given a slot at the tail of the ring, and the slot index goes back to the issuer as the instruction's result tag. Execution units finish in any order and write their results into the slot named by the tag. Slots leave the buffer only from the head, one per cycle and in program order, once their result has arrived.

A fault seen during execution is stored in the slot and has no effect until that slot is the oldest one in the buffer. At that point the block raises an exception pulse with the stored cause and drops every slot. A mispredicted branch is recovered the same way on an external request: the tail is pulled back to the head and all in-flight slots are freed in one cycle.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `cm_valid` and `exc_valid` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both 1 at a clock edge) takes the slot whose index is shown on `alloc_tag` before that edge. Tags are handed out in sequence and wrap from DEPTH-1 to 0.
- R3: A result write stores `wr_value` in slot `wr_tag` and marks the slot complete. A write to a slot that holds no instruction is ignored, so a later allocation of that slot stays incomplete.
- R4: `cm_valid` is 1 only while the oldest slot is complete and has no fault. In that cycle `cm_kind`, `cm_dest` and `cm_value` show that slot, and the slot is retired at the next edge. At most one slot retires per cycle.
- R5: While the oldest slot is incomplete, nothing retires, even if younger slots are complete.
- R6: A fault flag given with a result does nothing until its slot is the oldest. Then `exc_valid` is 1 for one cycle with the stored cause on `exc_cause`, `cm_valid` is 0, allocation is refused, and at the next edge every slot is freed.
- R7: While `flush_in` is 1, nothing retires and allocation is refused. At the next edge every slot is freed and the tail equals the head, so the next tag handed out is the old head index.
- R8: When DEPTH slots are in use, `alloc_ready` is 0 and an allocation request has no effect.
- R9: An allocation, a result write and a retirement may all happen in the same cycle.
- R10: The kind code is carried unchanged from `alloc_kind` to `cm_kind`: 0 = register write, 1 = store, 2 = branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request for a new slot |
| alloc_kind | input | 2 | Kind of the new instruction (0 reg, 1 store, 2 branch) |
| alloc_dest | input | DEST_W | Destination register of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Index of the slot the next allocation takes |
| wr_valid | input | 1 | Result broadcast valid |
| wr_tag | input | TAG_W | Slot the result belongs to |
| wr_value | input | DATA_W | Result value |
| wr_exc | input | 1 | The instruction faulted |
| wr_cause | input | CAUSE_W | Fault cause code |
| flush_in | input | 1 | Branch misprediction: drop all slots |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_kind | output | 2 | Kind of the retiring slot |
| cm_dest | output | DEST_W | Destination of the retiring slot |
| cm_value | output | DATA_W | Value of the retiring slot |
| exc_valid | output | 1 | Oldest slot faulted; buffer is being cleared |
| exc_cause | output | CAUSE_W | Cause stored with the faulting slot |

## Verification
The bench builds the buffer with DEPTH = 4, DATA_W = 16, DEST_W = 5 and CAUSE_W = 4. With only four slots, a short run fills the ring and wraps both pointers several times. Retirement therefore crosses the DEPTH-1 to 0 boundary, a flush or fault can leave the head at a non-zero index, and the full-refusal case comes up without long sequences. The 16-bit values keep the table rows short while still telling every result apart.

// File: rtl/retire_queue_pkg.sv
// Shared definitions for the reorder buffer.
// Assumes: kind codes are decoded only by retirement consumers.
package retire_queue_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } inst_kind_e;

    // Advance a ring index by one, wrapping at the ring size.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned size);
        return (idx == size - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/retire_queue_ptrs.sv
// Head/tail pointers and occupancy counter of the ring.
// Assumes: retire_fire and alloc_fire are already qualified (no retire when
// empty, no alloc when full), and both are 0 whenever discard is 1.
module retire_queue_ptrs #(
    parameter int DEPTH = 8,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             retire_fire,
    input  logic             discard,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    import retire_queue_pkg::*;

    logic [TAG_W-1:0] head_inc;
    logic [TAG_W-1:0] tail_inc;

    // Next positions after one step.
    always_comb begin
        head_inc = TAG_W'(ring_next(int'(head), DEPTH));
        tail_inc = TAG_W'(ring_next(int'(tail), DEPTH));
    end

    // Head moves on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (retire_fire) begin
            head <= head_inc;
        end
    end

    // Tail moves on allocation and snaps to head on discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (discard) begin
            tail <= head;
        end else if (alloc_fire) begin
            tail <= tail_inc;
        end
    end

    // Occupancy counter distinguishes full from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (discard) begin
            count <= '0;
        end else if (alloc_fire && !retire_fire) begin
            count <= count + 1'b1;
        end else if (retire_fire && !alloc_fire) begin
            count <= count - 1'b1;
        end
    end

    // Full flag from the counter.
    always_comb begin
        full = (count == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/retire_queue_slots.sv
// Storage for all ring slots plus a read port at the head index.
// Assumes: the allocation target is never busy; a result write only lands
// in a slot that is busy at the edge.
module retire_queue_slots #(
    parameter int DEPTH   = 8,
    parameter int DEST_W  = 5,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_fire,
    input  logic [TAG_W-1:0]   alloc_idx,
    input  logic [1:0]         alloc_kind,
    input  logic [DEST_W-1:0]  alloc_dest,
    input  logic               wr_valid,
    input  logic [TAG_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_value,
    input  logic               wr_exc,
    input  logic [CAUSE_W-1:0] wr_cause,
    input  logic               retire_fire,
    input  logic               discard,
    input  logic [TAG_W-1:0]   rd_idx,
    output logic               rd_busy,
    output logic               rd_done,
    output logic               rd_exc,
    output logic [CAUSE_W-1:0] rd_cause,
    output logic [1:0]         rd_kind,
    output logic [DEST_W-1:0]  rd_dest,
    output logic [DATA_W-1:0]  rd_value
);
    logic               busy_v  [DEPTH];
    logic               done_v  [DEPTH];
    logic               exc_v   [DEPTH];
    logic [CAUSE_W-1:0] cause_v [DEPTH];
    logic [1:0]         kind_v  [DEPTH];
    logic [DEST_W-1:0]  dest_v  [DEPTH];
    logic [DATA_W-1:0]  value_v [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [TAG_W-1:0] MY_IDX = TAG_W'(i);

        logic               busy_q;
        logic               done_q;
        logic               exc_q;
        logic [CAUSE_W-1:0] cause_q;
        logic [1:0]         kind_q;
        logic [DEST_W-1:0]  dest_q;
        logic [DATA_W-1:0]  value_q;
        logic               take_alloc;
        logic               take_write;
        logic               take_retire;

        // Per-slot event decode.
        always_comb begin
            take_alloc  = alloc_fire  && (alloc_idx == MY_IDX);
            take_write  = wr_valid    && (wr_idx == MY_IDX) && busy_q;
            take_retire = retire_fire && (rd_idx == MY_IDX);
        end

        // Occupancy and completion state of the slot.
        always_ff @(posedge clk) begin
            if (!rst_n || discard) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
            end else if (take_alloc) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
            end else if (take_retire) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
                exc_q  <= 1'b0;
            end else if (take_write) begin
                done_q <= 1'b1;
                exc_q  <= wr_exc;
            end
        end

        // Payload captured at allocation and at result write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_q  <= '0;
                dest_q  <= '0;
                value_q <= '0;
                cause_q <= '0;
            end else begin
                if (take_alloc) begin
                    kind_q <= alloc_kind;
                    dest_q <= alloc_dest;
                end
                if (take_write) begin
                    value_q <= wr_value;
                    cause_q <= wr_cause;
                end
            end
        end

        assign busy_v[i]  = busy_q;
        assign done_v[i]  = done_q;
        assign exc_v[i]   = exc_q;
        assign cause_v[i] = cause_q;
        assign kind_v[i]  = kind_q;
        assign dest_v[i]  = dest_q;
        assign value_v[i] = value_q;
    end

    // Read port at the selected slot.
    always_comb begin
        rd_busy  = busy_v[rd_idx];
        rd_done  = done_v[rd_idx];
        rd_exc   = exc_v[rd_idx];
        rd_cause = cause_v[rd_idx];
        rd_kind  = kind_v[rd_idx];
        rd_dest  = dest_v[rd_idx];
        rd_value = value_v[rd_idx];
    end

endmodule

// File: rtl/retire_queue_decide.sv
// Retirement decision for the oldest slot.
// Assumes: head state inputs come straight from slot storage; flush has
// priority over both a normal retirement and a fault.
module retire_queue_decide (
    input  logic head_busy,
    input  logic head_done,
    input  logic head_exc,
    input  logic flush_req,
    output logic retire_fire,
    output logic fault_fire,
    output logic discard
);
    // Choose between retire, fault and discard.
    always_comb begin
        retire_fire = head_busy && head_done && !head_exc && !flush_req;
        fault_fire  = head_busy && head_done &&  head_exc && !flush_req;
        discard     = flush_req || fault_fire;
    end

endmodule

// File: rtl/retire_queue.sv
// Reorder buffer top: allocation at the tail, indexed result writes,
// in-order retirement at the head, deferred faults and full flush.
// Assumes: issuers respect alloc_ready; wr_tag names a tag handed out earlier.
module retire_queue #(
    parameter int DEPTH   = 8,
    parameter int DEST_W  = 5,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [1:0]         alloc_kind,
    input  logic [DEST_W-1:0]  alloc_dest,
    output logic               alloc_ready,
    output logic [TAG_W-1:0]   alloc_tag,
    input  logic               wr_valid,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_value,
    input  logic               wr_exc,
    input  logic [CAUSE_W-1:0] wr_cause,
    input  logic               flush_in,
    output logic               cm_valid,
    output logic [1:0]         cm_kind,
    output logic [DEST_W-1:0]  cm_dest,
    output logic [DATA_W-1:0]  cm_value,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]   head_idx;
    logic [TAG_W-1:0]   tail_idx;
    logic [CNT_W-1:0]   occ;
    logic               is_full;
    logic               alloc_fire;
    logic               retire_fire;
    logic               fault_fire;
    logic               discard;
    logic               h_busy;
    logic               h_done;
    logic               h_exc;
    logic [CAUSE_W-1:0] h_cause;
    logic [1:0]         h_kind;
    logic [DEST_W-1:0]  h_dest;
    logic [DATA_W-1:0]  h_value;

    retire_queue_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .discard     (discard),
        .head        (head_idx),
        .tail        (tail_idx),
        .count       (occ),
        .full        (is_full)
    );

    retire_queue_slots #(
        .DEPTH   (DEPTH),
        .DEST_W  (DEST_W),
        .DATA_W  (DATA_W),
        .CAUSE_W (CAUSE_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .alloc_idx   (tail_idx),
        .alloc_kind  (alloc_kind),
        .alloc_dest  (alloc_dest),
        .wr_valid    (wr_valid && !discard),
        .wr_idx      (wr_tag),
        .wr_value    (wr_value),
        .wr_exc      (wr_exc),
        .wr_cause    (wr_cause),
        .retire_fire (retire_fire),
        .discard     (discard),
        .rd_idx      (head_idx),
        .rd_busy     (h_busy),
        .rd_done     (h_done),
        .rd_exc      (h_exc),
        .rd_cause    (h_cause),
        .rd_kind     (h_kind),
        .rd_dest     (h_dest),
        .rd_value    (h_value)
    );

    retire_queue_decide u_decide (
        .head_busy   (h_busy),
        .head_done   (h_done),
        .head_exc    (h_exc),
        .flush_req   (flush_in),
        .retire_fire (retire_fire),
        .fault_fire  (fault_fire),
        .discard     (discard)
    );

    // Allocation handshake at the tail.
    always_comb begin
        alloc_ready = !is_full && !discard;
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_tag   = tail_idx;
    end

    // Retirement and fault outputs from the head slot.
    always_comb begin
        cm_valid  = retire_fire;
        cm_kind   = h_kind;
        cm_dest   = h_dest;
        cm_value  = h_value;
        exc_valid = fault_fire;
        exc_cause = h_cause;
    end

endmodule

// File: rtl/retire_queue_chk.sv
// Property checker for the reorder buffer, bound into every instance.
module retire_queue_chk #(
    parameter int DEPTH = 8,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             cm_valid,
    input logic             exc_valid,
    input logic             flush_in,
    input logic [TAG_W-1:0] head,
    input logic [CNT_W-1:0] count,
    input logic             full
);
    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R8
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);

    // R4
    single_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cm_valid && exc_valid));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_valid && !exc_valid && !flush_in) |=> $stable(head));

    // R6
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (count == '0));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_in |=> (count == '0));

    // R4
    retire_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && (DEPTH > 1)) |=> (head != $past(head)));

endmodule

bind retire_queue retire_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .cm_valid    (cm_valid),
    .exc_valid   (exc_valid),
    .flush_in    (flush_in),
    .head        (head_idx),
    .count       (occ),
    .full        (is_full)
);

// File: tb/retire_queue_bench.sv
// Self-checking bench: table-driven sequence, then directed corner cases.
module retire_queue_bench;
    localparam int DEPTH   = 4;
    localparam int DEST_W  = 5;
    localparam int DATA_W  = 16;
    localparam int CAUSE_W = 4;
    localparam int TAG_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               alloc_valid;
    logic [1:0]         alloc_kind;
    logic [DEST_W-1:0]  alloc_dest;
    logic               alloc_ready;
    logic [TAG_W-1:0]   alloc_tag;
    logic               wr_valid;
    logic [TAG_W-1:0]   wr_tag;
    logic [DATA_W-1:0]  wr_value;
    logic               wr_exc;
    logic [CAUSE_W-1:0] wr_cause;
    logic               flush_in;
    logic               cm_valid;
    logic [1:0]         cm_kind;
    logic [DEST_W-1:0]  cm_dest;
    logic [DATA_W-1:0]  cm_value;
    logic               exc_valid;
    logic [CAUSE_W-1:0] exc_cause;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    retire_queue #(
        .DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
    ) u_retire_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_value(wr_value),
        .wr_exc(wr_exc), .wr_cause(wr_cause), .flush_in(flush_in),
        .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_dest(cm_dest), .cm_value(cm_value),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    typedef struct packed {
        logic        av;
        logic [1:0]  ak;
        logic [4:0]  ad;
        logic        wv;
        logic [1:0]  wt;
        logic [15:0] wval;
        logic        we;
        logic        fl;
        logic        ar;
        logic [1:0]  at;
        logic        cv;
        logic [1:0]  ck;
        logic [4:0]  cd;
        logic [15:0] cval;
        logic        xv;
        logic [3:0]  xc;
    } vec_t;

    localparam int NV = 20;
    // Fault cause is driven as the low nibble of the written value.
    localparam vec_t VECS [NV] = '{
        // R2 R10: register-write slot gets tag 0
        '{1'b1, 2'd0, 5'd3,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R2 R3: store slot gets tag 1, result for tag 0
        '{1'b1, 2'd1, 5'd4,  1'b1, 2'd0, 16'h1111, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R4 R9 R10: branch alloc while slot 0 retires
        '{1'b1, 2'd2, 5'd0,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd0, 5'd3,  16'h1111, 1'b0, 4'd0},
        // R5: younger slot 2 completes first
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd2, 16'h2222, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R5: head still incomplete, no retirement
        '{1'b0, 2'd0, 5'd0,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R5: head result arrives
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd1, 16'h3333, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R4 R10: store retires
        '{1'b0, 2'd0, 5'd0,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 2'd1, 5'd4,  16'h3333, 1'b0, 4'd0},
        // R4 R10: branch retires next cycle
        '{1'b0, 2'd0, 5'd0,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 2'd2, 5'd0,  16'h2222, 1'b0, 4'd0},
        // R2: tag 3
        '{1'b1, 2'd0, 5'd7,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R2: tag wraps to 0
        '{1'b1, 2'd0, 5'd8,  1'b1, 2'd3, 16'h4444, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R9: alloc, write and retire together
        '{1'b1, 2'd0, 5'd9,  1'b1, 2'd0, 16'h5555, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 2'd0, 5'd7,  16'h4444, 1'b0, 4'd0},
        // R4: head wraps to slot 0
        '{1'b1, 2'd0, 5'd10, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd0, 5'd8,  16'h5555, 1'b0, 4'd0},
        // R6: fault recorded in slot 1 only
        '{1'b1, 2'd0, 5'd11, 1'b1, 2'd1, 16'h6666, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R6: fault raised at head, alloc refused
        '{1'b1, 2'd0, 5'd12, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b1, 4'd6},
        // R6: buffer cleared, tail equals head 1
        '{1'b1, 2'd0, 5'd13, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R3: head result
        '{1'b1, 2'd0, 5'd14, 1'b1, 2'd1, 16'h7777, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R7: flush suppresses ready head and alloc
        '{1'b1, 2'd0, 5'd15, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R7: next tag is old head index 1
        '{1'b1, 2'd0, 5'd16, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R3
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd1, 16'h8888, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 5'd0,  16'h0000, 1'b0, 4'd0},
        // R4
        '{1'b0, 2'd0, 5'd0,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd0, 5'd16, 16'h8888, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic av, input logic [1:0] ak, input logic [4:0] ad,
                         input logic wv, input logic [1:0] wt, input logic [15:0] wval,
                         input logic we, input logic fl);
        @(negedge clk);
        alloc_valid = av; alloc_kind = ak; alloc_dest = ad;
        wr_valid = wv; wr_tag = wt; wr_value = wval; wr_exc = we;
        wr_cause = wval[3:0]; flush_in = fl;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_kind = '0; alloc_dest = '0;
        wr_valid = 1'b0; wr_tag = '0; wr_value = '0; wr_exc = 1'b0;
        wr_cause = '0; flush_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1", "alloc_ready", int'(alloc_ready), 1);
        chk("R1", "alloc_tag",   int'(alloc_tag),   0);
        chk("R1", "cm_valid",    int'(cm_valid),    0);
        chk("R1", "exc_valid",   int'(exc_valid),   0);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].av, VECS[v].ak, VECS[v].ad, VECS[v].wv,
                  VECS[v].wt, VECS[v].wval, VECS[v].we, VECS[v].fl);
            chk($sformatf("vec%0d", v), "alloc_ready", int'(alloc_ready), int'(VECS[v].ar));
            chk($sformatf("vec%0d", v), "alloc_tag",   int'(alloc_tag),   int'(VECS[v].at));
            chk($sformatf("vec%0d", v), "cm_valid",    int'(cm_valid),    int'(VECS[v].cv));
            chk($sformatf("vec%0d", v), "exc_valid",   int'(exc_valid),   int'(VECS[v].xv));
            if (VECS[v].cv) begin
                chk($sformatf("vec%0d", v), "cm_kind",  int'(cm_kind),  int'(VECS[v].ck));
                chk($sformatf("vec%0d", v), "cm_dest",  int'(cm_dest),  int'(VECS[v].cd));
                chk($sformatf("vec%0d", v), "cm_value", int'(cm_value), int'(VECS[v].cval));
            end
            if (VECS[v].xv) begin
                chk($sformatf("vec%0d", v), "exc_cause", int'(exc_cause), int'(VECS[v].xc));
            end
        end

        // R1: reset again mid-run clears all state
        do_reset();
        chk("R1", "alloc_tag after reset", int'(alloc_tag), 0);
        chk("R1", "cm_valid after reset",  int'(cm_valid),  0);

        // R3: write to a free slot is ignored
        drive(1'b0, 2'd0, 5'd0, 1'b1, 2'd0, 16'h9999, 1'b0, 1'b0);
        drive(1'b1, 2'd0, 5'd21, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        chk("R3", "alloc_tag", int'(alloc_tag), 0);
        drive(1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        chk("R3", "ignored write cm_valid", int'(cm_valid), 0);
        drive(1'b0, 2'd0, 5'd0, 1'b1, 2'd0, 16'hAAAA, 1'b0, 1'b0);
        chk("R3", "cm_valid before complete", int'(cm_valid), 0);
        drive(1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        chk("R3", "cm_valid", int'(cm_valid), 1);
        chk("R3", "cm_value", int'(cm_value), 16'hAAAA);
        chk("R3", "cm_dest",  int'(cm_dest),  21);

        // R8: fill all four slots starting at index 1
        for (int k = 0; k < DEPTH; k++) begin
            drive(1'b1, 2'd1, 5'(k + 1), 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
            chk("R8", "alloc_ready while filling", int'(alloc_ready), 1);
            chk("R2", "tag while filling", int'(alloc_tag), (k + 1) % DEPTH);
        end
        drive(1'b1, 2'd0, 5'd30, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        chk("R8", "alloc_ready when full", int'(alloc_ready), 0);
        // Complete slots youngest first; nothing retires until the head is done.
        for (int k = DEPTH - 1; k >= 0; k--) begin
            drive(1'b0, 2'd0, 5'd0, 1'b1, 2'((k + 1) % DEPTH), 16'(16'hB000 + k), 1'b0, 1'b0);
            chk("R5", "no retire before head", int'(cm_valid), 0);
        end
        for (int k = 0; k < DEPTH; k++) begin
            drive(1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
            chk("R4", "drain cm_valid", int'(cm_valid), 1);
            chk("R4", "drain order",    int'(cm_dest),  k + 1);
            chk("R4", "drain value",    int'(cm_value), 16'hB000 + k);
            chk("R10", "drain kind",    int'(cm_kind),  1);
        end
        drive(1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        chk("R8", "refused alloc left no slot", int'(cm_valid), 0);
        chk("R8", "tail unchanged by refusal", int'(alloc_tag), 1);

        finish_run();
    end

endmodule